// File: doc/BRIEF.md
# Line Switch State Controller

This block commands the four switch enables of a telephone line interface: a pair of line-break switches that connect the subscriber loop to the speech circuit and a pair of ringing switches that connect it to the ringing source. It chooses among three switch configurations: talk, ringing and all-off. When the line moves from ringing back to talk, it can open the ringing pair before it closes the line-break pair, or close the line-break pair before it opens the ringing pair. A run-time count sets the length of the gap or overlap in clock cycles.

Two fault flags can override the user: a supply-good flag from an external comparator and a battery-present flag. Both pass through a two-flop synchronizer. If the supply is lost, a lockout is latched and all switches are forced open. The lockout is cleared only when the supply is good and the active-low latch input is low. If the battery is lost, all switches are forced open but no lockout is latched. The latch input works as a transparent enable. While it is high, the present configuration is held. While it is low, the ringing request is followed. A latch pin that is left floating reads high, and so the block stays locked out through power-up.

Top module: `lsw_ctrl`

## Requirements
- R1: In talk, `brk_en` = 11, `ring_en` = 00 and `state_code` = 01.
- R2: In ringing, `brk_en` = 00, `ring_en` = 11 and `state_code` = 10.
- R3: After reset, the state is all-off with `lockout` = 1. All-off drives `brk_en` = 00, `ring_en` = 00 and `state_code` = 00.
- R4: With `mbb_mode` = 0 and `gap_cycles` = N > 0, dropping `ring_req` in ringing opens all four switches for exactly N cycles, then enters talk. `state_code` stays 10 until talk is reached.
- R5: With `mbb_mode` = 1 and N > 0, dropping `ring_req` in ringing closes all four switches for exactly N cycles, then enters talk. `state_code` stays 10 during the overlap. Both pairs are closed together only during this overlap.
- R6: With `gap_cycles` = 0, ringing changes to talk in a single clock, in either mode.
- R7: A low `supply_ok` forces all-off and sets `lockout` on the third rising edge after the input falls. While the supply stays low, `latch_n` and `ring_req` have no effect.
- R8: After the supply recovers, the block stays all-off and locked while `latch_n` is high. The first edge that sees `latch_n` low clears `lockout`. The request is applied on the edge after that.
- R9: A low `battery_ok` forces all-off on the third rising edge and does not set `lockout`. Commands are ignored while the battery is low. Once it returns, a command is taken one edge after `latch_n` goes low.
- R10: When not locked out, `latch_n` high holds the present state. With `latch_n` low, `ring_req` = 1 selects ringing and `ring_req` = 0 selects talk, one edge later. From all-off, talk and ringing are both entered directly.
- R11: Talk changes to ringing in a single clock, without a gap or overlap sequence.
- R12: A started ringing-to-talk sequence runs to talk even if `ring_req` rises or `latch_n` goes high during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_req | input | 1 | 1 requests ringing, 0 requests talk |
| latch_n | input | 1 | Active-low command enable and lockout release |
| supply_ok | input | 1 | Supply-good comparator output, asynchronous |
| battery_ok | input | 1 | Battery-present flag, asynchronous |
| mbb_mode | input | 1 | 0 gives break-before-make, 1 gives make-before-break |
| gap_cycles | input | CNT_W | Gap or overlap length in cycles |
| brk_en | output | NSW | Line-break switch enables, 1 = closed |
| ring_en | output | NSW | Ringing switch enables, 1 = closed |
| state_code | output | 2 | 00 all-off, 01 talk, 10 ringing or ringing-to-talk in progress |
| lockout | output | 1 | Under-voltage lockout active |

## Verification
The assertions assume that `ring_req`, `latch_n`, `mbb_mode` and `gap_cycles` are synchronous to `clk`, and that only the two fault flags arrive asynchronously. The bench drives every input just after a rising edge and holds it for a whole cycle. Before it checks any recovery, it holds a fault flag at its new level for at least the synchronizer depth. It changes the gap count and the mode only while the controller is outside a sequence, so each sequence length matches the count that was present at entry.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_TALK = 3'd1,
    ST_RING = 3'd2,
    ST_GAP  = 3'd3,
    ST_OVL  = 3'd4
  } lsw_state_e;

  localparam logic [1:0] CODE_OFF  = 2'b00;
  localparam logic [1:0] CODE_TALK = 2'b01;
  localparam logic [1:0] CODE_RING = 2'b10;
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  // Resets to 0: every flag reads "not good" until it has crossed the chain.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/lsw_lockout.sv
module lsw_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_s,
  input  logic latch_n,
  output logic lock_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b1;
    else if (!supply_s) lock_q <= 1'b1;
    else if (!latch_n)  lock_q <= 1'b0;
  end

  p_lock_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_s |=> lock_q);

  p_lock_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(supply_s) && !$past(latch_n)));
endmodule

// File: rtl/lsw_seq.sv
module lsw_seq
  import lsw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_s,
  input  logic             battery_s,
  input  logic             lock_q,
  input  logic             latch_n,
  input  logic             ring_req,
  input  logic             mbb_mode,
  input  logic [CNT_W-1:0] gap_cycles,
  output lsw_state_e       st
);
  lsw_state_e       st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             fault, accept;

  assign fault  = !supply_s || !battery_s;
  assign accept = !lock_q && !latch_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (fault) begin
      st_n  = ST_OFF;
      cnt_n = '0;
    end else begin
      unique case (st)
        ST_OFF, ST_TALK: begin
          if (accept) st_n = ring_req ? ST_RING : ST_TALK;
        end
        ST_RING: begin
          if (accept && !ring_req) begin
            if (gap_cycles == '0) begin
              st_n = ST_TALK;
            end else begin
              st_n  = mbb_mode ? ST_OVL : ST_GAP;
              cnt_n = gap_cycles - 1'b1;
            end
          end
        end
        ST_GAP, ST_OVL: begin
          if (cnt == '0) st_n = ST_TALK;
          else           cnt_n = cnt - 1'b1;
        end
        default: st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  p_batt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !battery_s |=> st == ST_OFF);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_n && supply_s && battery_s &&
     (st == ST_OFF || st == ST_TALK || st == ST_RING)) |=> st == $past(st));

  p_seq_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_GAP || st == ST_OVL) && !fault) |=>
      (st == ST_TALK || st == $past(st)));
endmodule

// File: rtl/lsw_drive.sv
module lsw_drive
  import lsw_pkg::*;
#(
  parameter int NSW = 2
) (
  input  lsw_state_e     st,
  output logic [NSW-1:0] brk_en,
  output logic [NSW-1:0] ring_en,
  output logic [1:0]     state_code
);
  logic brk_on, ring_on;

  assign brk_on  = (st == ST_TALK) || (st == ST_OVL);
  assign ring_on = (st == ST_RING) || (st == ST_OVL);

  for (genvar i = 0; i < NSW; i++) begin : g_sw
    assign brk_en[i]  = brk_on;
    assign ring_en[i] = ring_on;
  end

  always_comb begin
    unique case (st)
      ST_TALK:                 state_code = CODE_TALK;
      ST_RING, ST_GAP, ST_OVL: state_code = CODE_RING;
      default:                 state_code = CODE_OFF;
    endcase
  end
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int NSW         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_req,
  input  logic             latch_n,
  input  logic             supply_ok,
  input  logic             battery_ok,
  input  logic             mbb_mode,
  input  logic [CNT_W-1:0] gap_cycles,
  output logic [NSW-1:0]   brk_en,
  output logic [NSW-1:0]   ring_en,
  output logic [1:0]       state_code,
  output logic             lockout
);
  localparam int NFLAG = 2;

  logic [NFLAG-1:0] flags_s;
  logic             lock_q;
  lsw_state_e       st;

  lsw_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({battery_ok, supply_ok}),
    .q_sync  (flags_s)
  );

  lsw_lockout u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_s (flags_s[0]),
    .latch_n  (latch_n),
    .lock_q   (lock_q)
  );

  lsw_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_s   (flags_s[0]),
    .battery_s  (flags_s[1]),
    .lock_q     (lock_q),
    .latch_n    (latch_n),
    .ring_req   (ring_req),
    .mbb_mode   (mbb_mode),
    .gap_cycles (gap_cycles),
    .st         (st)
  );

  lsw_drive #(.NSW(NSW)) u_drive (
    .st         (st),
    .brk_en     (brk_en),
    .ring_en    (ring_en),
    .state_code (state_code)
  );

  assign lockout = lock_q;

  p_off_in_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> (brk_en == '0 && ring_en == '0 && state_code == CODE_OFF));

  p_overlap_from_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|brk_en && |ring_en) |-> (state_code == CODE_RING && !lockout));
endmodule

// File: tb/tb_lsw_ctrl.sv
module tb_lsw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ring_req = 1'b0, latch_n = 1'b1;
  logic       supply_ok = 1'b1, battery_ok = 1'b1, mbb_mode = 1'b0;
  logic [7:0] gap_cycles = 8'd0;
  logic [1:0] brk_en, ring_en, state_code;
  logic       lockout;

  int n_chk = 0, n_bad = 0;

  // {lockout, brk_en, ring_en, state_code}
  localparam logic [6:0] E_OFFL = 7'b1_00_00_00;
  localparam logic [6:0] E_OFF  = 7'b0_00_00_00;
  localparam logic [6:0] E_TALK = 7'b0_11_00_01;
  localparam logic [6:0] E_RING = 7'b0_00_11_10;
  localparam logic [6:0] E_GAP  = 7'b0_00_00_10;
  localparam logic [6:0] E_OVL  = 7'b0_11_11_10;

  always #10 clk = ~clk;

  lsw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ring_req(ring_req), .latch_n(latch_n),
    .supply_ok(supply_ok), .battery_ok(battery_ok), .mbb_mode(mbb_mode),
    .gap_cycles(gap_cycles), .brk_en(brk_en), .ring_en(ring_en),
    .state_code(state_code), .lockout(lockout)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {lockout, brk_en, ring_en, state_code};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R3 reset state", E_OFFL);
    step(5);
    chk("R8 lockout held with latch high at power-up", E_OFFL);

    latch_n = 1'b0; ring_req = 1'b0;
    step(1);
    chk("R8 lockout cleared, still off", E_OFF);
    step(1);
    chk("R1 R10 talk accepted", E_TALK);
    ring_req = 1'b1;
    step(1);
    chk("R2 R11 talk to ringing direct", E_RING);
    latch_n = 1'b1; ring_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R10 latch high holds ringing", E_RING);
    end

    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n <= 6; n++) begin
        latch_n = 1'b0; ring_req = 1'b1;
        step(1);
        chk("R2 ringing before sequence", E_RING);
        mbb_mode = m[0]; gap_cycles = 8'(n);
        ring_req = 1'b0;
        step(1);
        for (int i = 0; i < n; i++) begin
          chk(m == 1 ? "R5 overlap cycle" : "R4 gap cycle", m == 1 ? E_OVL : E_GAP);
          if (i == 0) begin
            ring_req = 1'b1; latch_n = 1'b1;  // R12 disturbance
          end
          step(1);
        end
        chk(n == 0 ? "R6 zero-length swap" : "R12 sequence reached talk", E_TALK);
        latch_n = 1'b1;
        step(1);
        chk("R10 talk held after sequence", E_TALK);
      end
    end

    latch_n = 1'b0; ring_req = 1'b1;
    step(1);
    chk("R2 ringing before supply loss", E_RING);
    latch_n = 1'b1;
    supply_ok = 1'b0;
    step(1);
    chk("R7 synchronizer latency 1", E_RING);
    step(1);
    chk("R7 synchronizer latency 2", E_RING);
    step(1);
    chk("R7 forced off and locked", E_OFFL);
    latch_n = 1'b0; ring_req = 1'b0;
    step(3);
    chk("R7 commands ignored during supply loss", E_OFFL);
    latch_n = 1'b1;
    supply_ok = 1'b1;
    step(4);
    chk("R8 still locked after recovery", E_OFFL);
    latch_n = 1'b0; ring_req = 1'b1;
    step(1);
    chk("R8 release edge keeps off", E_OFF);
    step(1);
    chk("R8 R10 request applied after release", E_RING);
    ring_req = 1'b0; gap_cycles = 8'd0;
    step(1);
    chk("R6 ring to talk", E_TALK);

    latch_n = 1'b1;
    battery_ok = 1'b0;
    step(2);
    chk("R9 battery latency", E_TALK);
    step(1);
    chk("R9 battery loss forces off without lockout", E_OFF);
    latch_n = 1'b0; ring_req = 1'b1;
    step(2);
    chk("R9 commands ignored without battery", E_OFF);
    latch_n = 1'b1;
    battery_ok = 1'b1;
    step(4);
    chk("R9 stays off after battery returns", E_OFF);
    latch_n = 1'b0;
    step(1);
    chk("R9 R10 command taken one edge after latch low", E_RING);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule